// File: doc/BRIEF.md
# Random Word Generator Control Front End

This block puts a small register file in front of a pseudo-random word source. Software talks to it through a single-cycle read/write strobe interface with byte addresses. It can start two timed operations: a seeding pass that lasts 64 cycles and a self-check pass that lasts 32 cycles. Each operation raises a sticky completion flag when it ends. A successful seeding pass lets a 16-entry queue of 32-bit words fill from the source. Software then drains the queue one word per read.

A test input can inject a statistical failure into either operation. Failures are recorded in an error register and summarised in the status word. One level-sensitive interrupt line reports completion and error conditions, and each of the two causes has its own mask bit. The interrupt clear is error-aware: a plain interrupt clear is refused while an error is recorded. Only the error clear wipes both the error register and the completion flags.

Top module: `entropy_ctl`

## Requirements
- R1: After reset the control register reads 0x60 (both masks set), status and error read 0, the queue is empty, `irq` is low and `bus_rdata` is 0.
- R2: Reads return on `bus_rdata` one cycle after the strobe, and `bus_rdata` is 0 in cycles without a read. Offsets: 0x04 command (reads 0), 0x08 control (only bits 5 and 6 are stored), 0x0C status, 0x10 error, 0x14 queue. Writes to 0x0C, 0x10 and 0x14 change nothing.
- R3: Writing command bit 1 starts seeding. Status bit 5 becomes readable as 1 in the 65th cycle after the write edge, exactly 64 edges later.
- R4: Writing command bit 0 starts the self-check. Status bit 4 becomes set exactly 32 edges after the write edge. If both bits are written together, the self-check starts.
- R5: A start command written while an operation is running is ignored.
- R6: After a successful seeding pass the queue gains one word per cycle until it holds 16. Status bits 11:8 give the fill level and saturate at 15 when 16 words are held.
- R7: A read at 0x14 returns the oldest word and removes it. Words appear in the order of the generator x' = (x >> 1) XOR (x[0] ? 0x80200003 : 0), starting from the `LFSR_SEED` parameter. A read of an empty queue returns 0 and leaves the level unchanged.
- R8: If `force_stat_err` is high on the completion edge, a seeding pass sets error bit 3 and stops refill, and a self-check sets error bit 1. Status bit 16 is 1 whenever the error register is nonzero.
- R9: `irq` = ((status bit 4 or 5) and not control bit 5) or (error nonzero and not control bit 6). Masks never change status bits.
- R10: Command bit 4 clears both completion flags only when the error register is zero; otherwise it has no effect.
- R11: Command bit 5 zeroes the error register and both completion flags. A completion on the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| force_stat_err | input | 1 | Test input that makes the finishing operation fail |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The register path is tried in four patterns:
- clean passes, which show the exact 64- and 32-cycle lengths;
- a start overlapping a running operation, which separates ignoring a command from restarting;
- a forced seeding failure, which separates the blocked interrupt clear from the error clear and shows that refill stops;
- a forced self-check failure, which shows the error bit tied to that operation.

Queue reads cover full, partially drained and empty states, which separates the saturated level field from a wrapped one and the zero word of an empty read from stale data. A behavioural model with a word queue predicts `bus_rdata` and `irq` on every cycle.

// File: rtl/entropy_ctl_pkg.sv
package entropy_ctl_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_ERR  = 8'h10;
  localparam logic [7:0] OFS_FIFO = 8'h14;

  localparam int CMD_TEST = 0;
  localparam int CMD_SEED = 1;
  localparam int CMD_CLRI = 4;
  localparam int CMD_CLRE = 5;

  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  localparam int ST_TDONE  = 4;
  localparam int ST_SDONE  = 5;
  localparam int ST_LVL_LO = 8;
  localparam int ST_LVL_W  = 4;
  localparam int ST_ERR    = 16;

  localparam int ER_TEST = 1;
  localparam int ER_STAT = 3;

  typedef enum logic {OP_TEST = 1'b0, OP_SEED = 1'b1} op_e;
endpackage

// File: rtl/entropy_ctl_lfsr.sv
module entropy_ctl_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] word
);
  logic [W-1:0] st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (adv) st_n = {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else if (adv) st_q <= st_n;
  end

  assign word = st_q;

  // R7: the generator never locks up in the all-zero state
  a_r7_nonzero_state: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/entropy_ctl_fifo.sv
module entropy_ctl_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DEPTH-1:0][W-1:0] slots;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    logic         we;
    assign we = push && (wp_q == AW'(g));
    always_ff @(posedge clk) begin
      if (we) q <= wdata;
    end
    assign slots[g] = q;
  end

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push) wp_n = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_n = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  assign head  = slots[rp_q];
  assign count = cnt_q;

  // R6: the writer never pushes into a full queue
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  // R7: the reader never pops an empty queue
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/entropy_ctl_seq.sv
module entropy_ctl_seq
  import entropy_ctl_pkg::*;
#(
  parameter int SEED_CYC = 64,
  parameter int TEST_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_seed,
  input  logic go_test,
  output logic busy,
  output logic fin,
  output op_e  fin_op
);
  localparam int MAXC  = (SEED_CYC > TEST_CYC) ? SEED_CYC : TEST_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  op_e              op_q, op_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    op_n   = op_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else cnt_n = cnt_q - 1'b1;
    end else if (go_test) begin
      busy_n = 1'b1;
      op_n   = OP_TEST;
      cnt_n  = CNT_W'(TEST_CYC - 1);
    end else if (go_seed) begin
      busy_n = 1'b1;
      op_n   = OP_SEED;
      cnt_n  = CNT_W'(SEED_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_TEST;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
    end
  end

  assign busy   = busy_q;
  assign fin    = busy_q && (cnt_q == '0);
  assign fin_op = op_q;

  // R5: a running operation keeps its kind and counts down regardless of new starts
  a_r5_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && $stable(op_q) && cnt_q == $past(cnt_q) - 1'b1));
  // R3: an idle sequencer stays idle without a start request
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !go_seed && !go_test) |=> !busy_q);
endmodule

// File: rtl/entropy_ctl.sv
module entropy_ctl
  import entropy_ctl_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 16,
  parameter int          SEED_CYC   = 64,
  parameter int          TEST_CYC   = 32,
  parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              force_stat_err,
  output logic              irq
);
  localparam int CW      = $clog2(FIFO_DEPTH+1);
  localparam int LVL_MAX = (1 << ST_LVL_W) - 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic wdata_unused;
  assign wdata_unused = ^bus_wdata;

  // access decode
  logic wr_cmd, wr_ctrl, rd_fifo;
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign rd_fifo = bus_rd && (bus_addr == OFS_FIFO);

  // state
  logic mdone_q, mdone_n, merr_q, merr_n;
  logic tdone_q, tdone_n, sdone_q, sdone_n;
  logic etest_q, etest_n, estat_q, estat_n;
  logic seeded_q, seeded_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  // sequencer
  logic busy, fin;
  op_e  fin_op;
  logic go_seed, go_test;
  assign go_test = wr_cmd && bus_wdata[CMD_TEST];
  assign go_seed = wr_cmd && bus_wdata[CMD_SEED];

  entropy_ctl_seq #(.SEED_CYC(SEED_CYC), .TEST_CYC(TEST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s), .go_seed(go_seed), .go_test(go_test),
    .busy(busy), .fin(fin), .fin_op(fin_op)
  );

  // word source and queue
  logic [CW-1:0]     fifo_count;
  logic [DATA_W-1:0] fifo_head, src_word;
  logic              push, pop;
  assign push = seeded_q && (fifo_count < CW'(FIFO_DEPTH));
  assign pop  = rd_fifo && (fifo_count != '0);

  entropy_ctl_lfsr #(.W(DATA_W), .TAPS(DATA_W'(32'h8020_0003)), .SEED(DATA_W'(LFSR_SEED))) u_src (
    .clk(clk), .rst_n(rst_s), .adv(push), .word(src_word)
  );

  entropy_ctl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(push), .wdata(src_word), .pop(pop),
    .head(fifo_head), .count(fifo_count)
  );

  // status assembly
  logic                err_any;
  logic [ST_LVL_W-1:0] lvl;
  logic [DATA_W-1:0]   st_word, er_word, ct_word;
  assign err_any = etest_q || estat_q;

  always_comb begin
    if (fifo_count > CW'(LVL_MAX)) lvl = ST_LVL_W'(LVL_MAX);
    else lvl = ST_LVL_W'(fifo_count);
    st_word = '0;
    st_word[ST_TDONE] = tdone_q;
    st_word[ST_SDONE] = sdone_q;
    st_word[ST_LVL_LO +: ST_LVL_W] = lvl;
    st_word[ST_ERR] = err_any;
    er_word = '0;
    er_word[ER_TEST] = etest_q;
    er_word[ER_STAT] = estat_q;
    ct_word = '0;
    ct_word[CTL_MDONE] = mdone_q;
    ct_word[CTL_MERR]  = merr_q;
  end

  // next state
  always_comb begin
    mdone_n  = mdone_q;
    merr_n   = merr_q;
    tdone_n  = tdone_q;
    sdone_n  = sdone_q;
    etest_n  = etest_q;
    estat_n  = estat_q;
    seeded_n = seeded_q;
    rdata_n  = '0;

    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: rdata_n = ct_word;
        OFS_STAT: rdata_n = st_word;
        OFS_ERR:  rdata_n = er_word;
        OFS_FIFO: rdata_n = (fifo_count != '0) ? fifo_head : '0;
        default:  rdata_n = '0;
      endcase
    end

    if (wr_ctrl) begin
      mdone_n = bus_wdata[CTL_MDONE];
      merr_n  = bus_wdata[CTL_MERR];
    end

    if (wr_cmd && bus_wdata[CMD_CLRE]) begin
      etest_n = 1'b0;
      estat_n = 1'b0;
      tdone_n = 1'b0;
      sdone_n = 1'b0;
    end else if (wr_cmd && bus_wdata[CMD_CLRI] && !err_any) begin
      tdone_n = 1'b0;
      sdone_n = 1'b0;
    end

    if (fin) begin
      if (fin_op == OP_SEED) begin
        sdone_n  = 1'b1;
        seeded_n = !force_stat_err;
        if (force_stat_err) estat_n = 1'b1;
      end else begin
        tdone_n = 1'b1;
        if (force_stat_err) etest_n = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mdone_q  <= 1'b1;
      merr_q   <= 1'b1;
      tdone_q  <= 1'b0;
      sdone_q  <= 1'b0;
      etest_q  <= 1'b0;
      estat_q  <= 1'b0;
      seeded_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      mdone_q  <= mdone_n;
      merr_q   <= merr_n;
      tdone_q  <= tdone_n;
      sdone_q  <= sdone_n;
      etest_q  <= etest_n;
      estat_q  <= estat_n;
      seeded_q <= seeded_n;
      rdata_q  <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq = ((tdone_q || sdone_q) && !mdone_q) || (err_any && !merr_q);

  // R10: an interrupt clear with a recorded error leaves the completion flags alone
  a_r10_clri_blocked: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_cmd && bus_wdata[CMD_CLRI] && !bus_wdata[CMD_CLRE] && err_any && !fin)
      |=> $stable({tdone_q, sdone_q}));
  // R11: an error clear empties the error register and completion flags
  a_r11_clre_wipes: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_cmd && bus_wdata[CMD_CLRE] && !fin)
      |=> (!etest_q && !estat_q && !tdone_q && !sdone_q));
  // R8: a failed seeding pass halts the refill
  a_r8_fail_stops_refill: assert property (@(posedge clk) disable iff (!rst_s)
    (fin && fin_op == OP_SEED && force_stat_err) |=> !seeded_q);
  // R6: while seeded and not full, the queue grows by exactly one word per cycle
  a_r6_refill_rate: assert property (@(posedge clk) disable iff (!rst_s)
    (seeded_q && fifo_count < CW'(FIFO_DEPTH) && !pop) |=> fifo_count == $past(fifo_count) + 1'b1);
  // R5: completion flags can only rise on a completion edge
  a_r5_done_on_fin: assert property (@(posedge clk) disable iff (!rst_s)
    (!fin && !tdone_q && !sdone_q) |=> (!tdone_q && !sdone_q));
endmodule

// File: tb/entropy_ctl_tb.sv
module entropy_ctl_tb;
  localparam logic [31:0] SEED_TB = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        force_stat_err = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  entropy_ctl #(.LFSR_SEED(SEED_TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .force_stat_err(force_stat_err), .irq(irq)
  );

  function automatic logic [31:0] gen_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  // behavioural reference model
  logic [31:0] q[$];
  bit m_md, m_me, m_td, m_sd, m_et, m_es, m_seeded, m_busy, m_seed_op;
  int m_cnt;
  logic [31:0] m_gen, m_rdata;

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h0;
    int lvl = (q.size() > 15) ? 15 : q.size();
    s[4] = m_td; s[5] = m_sd; s[11:8] = lvl[3:0]; s[16] = m_et | m_es;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_md = 1; m_me = 1; m_td = 0; m_sd = 0; m_et = 0; m_es = 0;
      m_seeded = 0; m_busy = 0; m_seed_op = 0; m_cnt = 0;
      m_gen = SEED_TB; m_rdata = 0;
    end else begin
      automatic int  pre = q.size();
      automatic bit  fin = m_busy && (m_cnt == 0);
      automatic bit  eany = m_et | m_es;
      automatic bit  wcmd = bus_wr && bus_addr == 8'h04;
      automatic logic [31:0] rd = 0;
      if (bus_rd) begin
        case (bus_addr)
          8'h08: rd = {25'h0, m_me, m_md, 5'h0};
          8'h0C: rd = m_status();
          8'h10: rd = {28'h0, m_es, 1'b0, m_et, 1'b0};
          8'h14: if (pre > 0) rd = q.pop_front();
          default: rd = 0;
        endcase
      end
      if (m_seeded && pre < 16) begin
        q.push_back(m_gen);
        m_gen = gen_next(m_gen);
      end
      if (bus_wr && bus_addr == 8'h08) begin
        m_md = bus_wdata[5]; m_me = bus_wdata[6];
      end
      if (wcmd && bus_wdata[5]) begin
        m_et = 0; m_es = 0; m_td = 0; m_sd = 0;
      end else if (wcmd && bus_wdata[4] && !eany) begin
        m_td = 0; m_sd = 0;
      end
      if (fin) begin
        if (m_seed_op) begin
          m_sd = 1; m_seeded = !force_stat_err;
          if (force_stat_err) m_es = 1;
        end else begin
          m_td = 1;
          if (force_stat_err) m_et = 1;
        end
      end
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end else if (wcmd && bus_wdata[0]) begin
        m_busy = 1; m_seed_op = 0; m_cnt = 31;
      end else if (wcmd && bus_wdata[1]) begin
        m_busy = 1; m_seed_op = 1; m_cnt = 63;
      end
      m_rdata = rd;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      automatic bit m_irq = ((m_td | m_sd) & !m_md) | ((m_et | m_es) & !m_me);
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2 rdata per-cycle: actual %h expected %h", bus_rdata, m_rdata);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq per-cycle: actual %0b expected %0b", irq, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] s0, s1, s2;
    s0 = SEED_TB; s1 = gen_next(s0); s2 = gen_next(s1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cmp_en = 1;

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(8'h08, v); check("R1 control", v, 32'h60);
    rd(8'h0C, v); check("R1 status", v, 32'h0);
    rd(8'h10, v); check("R1 error", v, 32'h0);

    // R2 decode
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R2 control bits", v, 32'h60);
    wr(8'h08, 32'h0);         rd(8'h08, v); check("R2 control clear", v, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R2 status write ignored", v, 32'h0);
    rd(8'h10, v); check("R2 error write ignored", v, 32'h0);
    rd(8'h04, v); check("R2 command reads zero", v, 32'h0);

    // R4 self-check timing
    wr(8'h04, 32'h1);
    repeat (31) @(negedge clk);
    rd(8'h0C, v); check("R4 not yet done", v, 32'h0);
    rd(8'h0C, v); check("R4 done after 32", v, 32'h10);
    check("R9 irq on done", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h20);
    check("R9 done masked", {31'h0, irq}, 32'h0);
    rd(8'h0C, v); check("R9 mask keeps status", v, 32'h10);
    wr(8'h04, 32'h10);
    rd(8'h0C, v); check("R10 clear without error", v, 32'h0);
    wr(8'h08, 32'h0);

    // R5 start while busy is ignored
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h2);
    repeat (70) @(negedge clk);
    rd(8'h0C, v); check("R5 seed during self-check ignored", v, 32'h10);
    wr(8'h04, 32'h10);

    // R3 seeding timing, R6 refill and saturation
    wr(8'h04, 32'h2);
    repeat (63) @(negedge clk);
    rd(8'h0C, v); check("R3 not yet done", v, 32'h0);
    rd(8'h0C, v); check("R3 done after 64", v, 32'h20);
    repeat (20) @(negedge clk);
    rd(8'h0C, v); check("R6 full level saturates", v, 32'h0F20);

    // R7 word order
    rd(8'h14, v); check("R7 word 0", v, s0);
    rd(8'h14, v); check("R7 word 1", v, s1);
    rd(8'h14, v); check("R7 word 2", v, s2);
    wr(8'h04, 32'h10);
    rd(8'h0C, v); check("R10 clear done, refilled", v, 32'h0F00);

    // R8 seeding failure, R10 blocked clear, R11 error clear
    force_stat_err = 1;
    wr(8'h04, 32'h2);
    repeat (70) @(negedge clk);
    force_stat_err = 0;
    rd(8'h10, v); check("R8 seed error bit", v, 32'h8);
    rd(8'h0C, v); check("R8 summary error", v, 32'h1_0F20);
    check("R9 irq on error", {31'h0, irq}, 32'h1);
    wr(8'h04, 32'h10);
    rd(8'h0C, v); check("R10 clear refused with error", v, 32'h1_0F20);
    wr(8'h08, 32'h60);
    check("R9 both masked", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h40);
    check("R9 error masked, done unmasked", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h14, v); rd(8'h14, v);
    repeat (5) @(negedge clk);
    rd(8'h0C, v); check("R8 refill stopped", v, 32'h1_0E20);
    wr(8'h04, 32'h20);
    rd(8'h10, v); check("R11 error cleared", v, 32'h0);
    rd(8'h0C, v); check("R11 flags cleared", v, 32'h0E00);
    check("R11 irq low", {31'h0, irq}, 32'h0);

    // R8 self-check failure
    force_stat_err = 1;
    wr(8'h04, 32'h1);
    repeat (40) @(negedge clk);
    force_stat_err = 0;
    rd(8'h10, v); check("R8 self-check error bit", v, 32'h2);
    wr(8'h04, 32'h20);

    // R7 drain and empty read
    for (int i = 0; i < 14; i++) rd(8'h14, v);
    rd(8'h0C, v); check("R7 drained level", v, 32'h0);
    rd(8'h14, v); check("R7 empty read returns zero", v, 32'h0);
    rd(8'h0C, v); check("R7 empty level unchanged", v, 32'h0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule